// File: doc/BRIEF.md
# Bit-Serial Quadratic-System Keystream Core

This core generates a keystream over GF(2) by evaluating a fixed system of random quadratic polynomials in a secret state of `NVAR` bits. Each round evaluates `NOUT + NVAR` polynomials one after another. The first `NOUT` results leave the core as keystream bits. The remaining `NVAR` results become the next state. Only one monomial is handled per clock: the product of two state bits is gated by one public coefficient bit and folded into a one-bit accumulator. The coefficients are never stored. A small nonlinear feedback shift register produces them on the fly and is reseeded at the start of every round, so every round uses the same polynomial system.

Software or a surrounding controller first loads a state word while the core is idle and then pulses `start`. While the round runs the core raises `busy`. It emits each keystream bit with a one-cycle `ks_valid` pulse. It pulses `done` in the cycle after the new state is committed. Further rounds can then be started without reloading.

Top module: `mq_serial_core`

## Requirements
- R1: After reset is released, and before any start, `busy`, `ks_valid` and `done` are all low.
- R2: Polynomial k is computed as the XOR over all pairs (i, j) with 0 ≤ i ≤ j < NVAR of c·x[i]·x[j]. The pairs are visited with i outer ascending and j inner ascending from i. Polynomials run k = 0, 1, … in sequence, and each one consumes the next NVAR(NVAR+1)/2 coefficient bits.
- R3: The coefficient register is 16 bits wide. It is loaded with 16'hACE1 each time a round starts. The coefficient used for a monomial is bit 0 of the register. After each monomial the register shifts right, and bit 15 receives s[0]^s[2]^s[3]^s[5]^(s[7]&s[11]). Two rounds started from the same state therefore give the same keystream.
- R4: Polynomial k ends at clock M·(k+1) after the edge that accepts `start`, where M = NVAR(NVAR+1)/2. For k < NOUT its result appears on `ks_bit` with `ks_valid` high for exactly one cycle.
- R5: Result NOUT+b becomes state bit b. The whole new state is committed together at clock M·(NOUT+NVAR), and `done` pulses in that same cycle while `busy` falls.
- R6: A `start` pulse while `busy` is high is ignored. It neither shortens the running round nor launches another round.
- R7: A state load (`ld_valid`) while `busy` is high is ignored. Only the committed next state feeds the following round.
- R8: Every round produces exactly NOUT keystream pulses and one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load `ld_state` into the state register (honoured only when idle) |
| ld_state | input | NVAR | State value to load |
| start | input | 1 | Begin a round (honoured only when idle) |
| busy | output | 1 | A round is in progress |
| ks_valid | output | 1 | One-cycle strobe qualifying `ks_bit` |
| ks_bit | output | 1 | Keystream bit |
| done | output | 1 | One-cycle strobe: new state committed |

## Verification
The state is not visible at the ports. The hardest thing to confirm is therefore that the committed next state is correct and that a load during a busy round does not corrupt it. The stimulus chains rounds without reloading, so the keystream of each following round exposes the state committed by the round before. The stimulus also drives a junk load and a stray start deep inside a running round, then checks the next round's keystream against the model and confirms that the pulse timing is unchanged.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mq_st_e;
endpackage

// File: rtl/mq_coef_gen.sv
module mq_coef_gen #(
  parameter int          CGW  = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  output logic coef
);
  logic [CGW-1:0] s_q, s_d;
  logic           fb;
  logic           s_en;

  always_comb begin
    fb   = s_q[0] ^ s_q[2] ^ s_q[3] ^ s_q[5] ^ (s_q[7] & s_q[11]);
    s_en = restart | step;
    s_d  = s_q;
    if (restart)   s_d = CGW'(SEED);
    else if (step) s_d = {fb, s_q[CGW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= CGW'(SEED);
    else if (s_en) s_q <= s_d;
  end

  assign coef = s_q[0];

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !step) |=> $stable(coef));
endmodule

// File: rtl/mq_pair_walker.sv
module mq_pair_walker #(
  parameter int NVAR = 8,
  localparam int IW  = (NVAR > 1) ? $clog2(NVAR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  output logic [IW-1:0] ii,
  output logic [IW-1:0] jj,
  output logic          last_pair
);
  localparam logic [IW-1:0] TOP = IW'(NVAR - 1);

  logic [IW-1:0] ii_q, ii_d, jj_q, jj_d;
  logic          en;

  always_comb begin
    last_pair = (ii_q == TOP) && (jj_q == TOP);
    en        = restart | step;
    ii_d      = ii_q;
    jj_d      = jj_q;
    if (restart || last_pair) begin
      ii_d = '0;
      jj_d = '0;
    end else if (jj_q == TOP) begin
      ii_d = ii_q + 1'b1;
      jj_d = ii_q + 1'b1;
    end else begin
      jj_d = jj_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ii_q <= '0;
      jj_q <= '0;
    end else if (en) begin
      ii_q <= ii_d;
      jj_q <= jj_d;
    end
  end

  assign ii = ii_q;
  assign jj = jj_q;

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ii_q <= jj_q);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && last_pair) |=> (ii_q == '0 && jj_q == '0));
endmodule

// File: rtl/mq_serial_core.sv
module mq_serial_core
  import mq_pkg::*;
#(
  parameter int          NVAR = 8,
  parameter int          NOUT = 8,
  parameter int          CGW  = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_valid,
  input  logic [NVAR-1:0] ld_state,
  input  logic            start,
  output logic            busy,
  output logic            ks_valid,
  output logic            ks_bit,
  output logic            done
);
  localparam int NPOLY = NOUT + NVAR;
  localparam int PW    = $clog2(NPOLY);
  localparam int IW    = (NVAR > 1) ? $clog2(NVAR) : 1;

  mq_st_e          st_q, st_d;
  logic [NVAR-1:0] x_q, x_d, buf_q, buf_d, nxt_full;
  logic [PW-1:0]   pk_q, pk_d;
  logic            acc_q, acc_d;
  logic            ksv_q, ksv_d, ksb_q, ksb_d, done_q, done_d;
  logic            x_en, buf_en;

  logic            accept, run, coef, term, res;
  logic            poly_end, last_poly, commit, is_ks;
  logic [IW-1:0]   ii, jj;
  logic            last_pair;

  assign run    = (st_q == ST_RUN);
  assign accept = (st_q == ST_IDLE) && start;

  mq_pair_walker #(.NVAR(NVAR)) walk_i (
    .clk(clk), .rst_n(rst_n), .restart(accept), .step(run),
    .ii(ii), .jj(jj), .last_pair(last_pair)
  );

  mq_coef_gen #(.CGW(CGW), .SEED(SEED)) cgen_i (
    .clk(clk), .rst_n(rst_n), .restart(accept), .step(run), .coef(coef)
  );

  always_comb begin
    term      = coef & x_q[ii] & x_q[jj];
    res       = acc_q ^ term;
    poly_end  = run && last_pair;
    last_poly = (pk_q == PW'(NPOLY - 1));
    commit    = poly_end && last_poly;
    is_ks     = (pk_q < PW'(NOUT));
  end

  genvar b;
  generate
    for (b = 0; b < NVAR; b++) begin : g_buf
      logic wr;
      assign wr       = poly_end && (pk_q == PW'(NOUT + b));
      assign buf_d[b] = wr ? res : buf_q[b];
      if (b == NVAR - 1) begin : g_top
        assign nxt_full[b] = res;
      end else begin : g_low
        assign nxt_full[b] = buf_q[b];
      end
    end
  endgenerate

  always_comb begin
    st_d   = st_q;
    pk_d   = pk_q;
    acc_d  = acc_q;
    x_d    = x_q;
    x_en   = 1'b0;
    buf_en = poly_end && !is_ks;
    ksv_d  = poly_end && is_ks;
    ksb_d  = (poly_end && is_ks) ? res : ksb_q;
    done_d = commit;
    if (accept) begin
      st_d  = ST_RUN;
      pk_d  = '0;
      acc_d = 1'b0;
    end else if (run) begin
      acc_d = poly_end ? 1'b0 : res;
      if (poly_end) pk_d = last_poly ? '0 : pk_q + 1'b1;
      if (commit)   st_d = ST_IDLE;
    end
    if (commit) begin
      x_d  = nxt_full;
      x_en = 1'b1;
    end else if (st_q == ST_IDLE && ld_valid) begin
      x_d  = ld_state;
      x_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pk_q   <= '0;
      acc_q  <= 1'b0;
      x_q    <= '0;
      buf_q  <= '0;
      ksv_q  <= 1'b0;
      ksb_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pk_q   <= pk_d;
      acc_q  <= acc_d;
      if (x_en)   x_q   <= x_d;
      if (buf_en) buf_q <= buf_d;
      ksv_q  <= ksv_d;
      ksb_q  <= ksb_d;
      done_q <= done_d;
    end
  end

  assign busy     = run;
  assign ks_valid = ksv_q;
  assign ks_bit   = ksb_q;
  assign done     = done_q;

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |=> !ks_valid);
  p_valid_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> busy);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !ks_valid);
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  p_ld_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_valid && !commit) |=> $stable(x_q));
endmodule

// File: tb/mq_serial_core_tb_top.sv
module mq_serial_core_tb_top;
  localparam int N  = 8;
  localparam int R  = 8;
  localparam int M  = N * (N + 1) / 2;
  localparam int NP = N + R;
  localparam int NV = 6;
  localparam logic [N-1:0] KEYS [NV] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5, 8'h3C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [N-1:0] ld_state = '0;
  logic start = 1'b0;
  logic busy, ks_valid, ks_bit, done;

  int total = 0;
  int bad = 0;
  int gcyc = 0;
  logic [N-1:0] model_x = '0;

  always #5 clk = ~clk;

  mq_serial_core #(.NVAR(N), .NOUT(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_state(ld_state),
    .start(start), .busy(busy), .ks_valid(ks_valid), .ks_bit(ks_bit),
    .done(done)
  );

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<=150000", gcyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] model_round(input logic [N-1:0] x);
    logic [15:0] s;
    logic [NP-1:0] out;
    logic acc, fb;
    s = 16'hACE1;
    out = '0;
    for (int k = 0; k < NP; k++) begin
      acc = 1'b0;
      for (int i = 0; i < N; i++) begin
        for (int j = i; j < N; j++) begin
          acc = acc ^ (s[0] & x[i] & x[j]);
          fb = s[0] ^ s[2] ^ s[3] ^ s[5] ^ (s[7] & s[11]);
          s = {fb, s[15:1]};
        end
      end
      out[k] = acc;
    end
    return out;
  endfunction

  task automatic load_key(input logic [N-1:0] k);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_state = k;
    @(negedge clk);
    ld_valid = 1'b0;
    model_x = k;
  endtask

  task automatic run_round(input string tag, input int start_at, input int ld_at,
                           output logic [R-1:0] got);
    logic [NP-1:0] exp;
    int nks, done_cyc, c;
    logic timing_ok;
    exp = model_round(model_x);
    got = '0;
    nks = 0;
    done_cyc = -1;
    timing_ok = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (done_cyc < 0 && c < 2000) begin
      @(negedge clk);
      c++;
      start = (c == start_at);
      ld_valid = (c == ld_at);
      ld_state = 8'h5A;
      if (ks_valid) begin
        if (nks < R) got[nks] = ks_bit;
        if (c != M * (nks + 1)) timing_ok = 1'b0;
        nks++;
      end
      if (done) begin
        done_cyc = c;
        chk({"R5 busy low at done ", tag}, {31'd0, busy}, 32'd0);
      end
    end
    start = 1'b0;
    ld_valid = 1'b0;
    chk({"R8 keystream count ", tag}, nks, R);
    chk({"R2 keystream bits ", tag}, {24'd0, got}, {24'd0, exp[R-1:0]});
    chk({"R4 pulse timing ", tag}, {31'd0, timing_ok}, 32'd1);
    chk({"R5 done cycle ", tag}, done_cyc, M * NP);
    model_x = exp[NP-1:R];
  endtask

  initial begin
    logic [R-1:0] g1, g2;
    int spur;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 ks_valid after reset", {31'd0, ks_valid}, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {29'd0, busy, ks_valid, done}, 32'd0);

    // Vector table: load each state, then chain a second round (R2, R4, R5, R8)
    for (int v = 0; v < NV; v++) begin
      load_key(KEYS[v]);
      run_round($sformatf("v%0d first", v), -1, -1, g1);
      run_round($sformatf("v%0d chained R5", v), -1, -1, g2);
    end

    // R3: same state twice gives the same keystream
    load_key(8'hA5);
    run_round("R3 a", -1, -1, g1);
    load_key(8'hA5);
    run_round("R3 b", -1, -1, g2);
    chk("R3 repeat keystream", {24'd0, g2}, {24'd0, g1});

    // R6: stray start mid-round, then no extra round afterwards
    load_key(8'h6E);
    run_round("R6 stray start", 100, -1, g1);
    spur = 0;
    for (int q = 0; q < 60; q++) begin
      @(negedge clk);
      if (busy || ks_valid) spur++;
    end
    chk("R6 no relaunch", spur, 0);

    // R7: junk load mid-round is dropped; next round follows committed state
    load_key(8'hC3);
    run_round("R7 junk load", -1, 200, g1);
    run_round("R7 next round", -1, -1, g2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule